// File: doc/BRIEF.md
# Watchdog Timer with Second/Minute Count Unit

This block is a watchdog timer configured through a small register port. Software loads an 8-bit count. The count then falls by one per count unit, and the unit is either one second or one minute. When the count reaches zero, the block latches a sticky fired flag. It can also drive a reset pulse of fixed length. A count of zero means the watchdog is disarmed.

A timeout can also come from three other sources:
- a self-clearing force bit in the control register;
- an external force input, gated by an option bit;
- keyboard or mouse interrupt activity, which instead reloads the counter with the last armed value, each source enabled on its own.

A free-running one-second tick-enable input is the time base. An internal divide-by-60 prescaler turns it into minutes.

The fired flag must be cleared by software before another timeout can take effect. This lets the system read after the restart why the reset happened.

Top module: `wdt_top`

## Requirements
- R1: After reset, the three registers (options at address 0, count at address 1, control at address 2) read 0, and `wdt_reset_o` and `fired_o` are low. Address 3 always reads 0.
- R2: Writing a nonzero value to the count register arms the watchdog, or restarts it at that value. Writing 0 disarms it: the count stays 0 and never fires.
- R3: When options bit 3 is 0, each clock with `tick_1s_i` high lowers a nonzero count by one. Reading the count register returns the remaining count.
- R4: When options bit 3 is 1, the count falls once per 60 ticks. The tick phase restarts whenever the count register is written or reloaded.
- R5: When the count steps from 1 to 0, control bit 4 (fired) becomes 1 and `fired_o` rises. The count then stays at 0.
- R6: When options bit 1 is 1, each firing drives `wdt_reset_o` high for exactly PULSE_CYCLES clocks, starting the clock after the firing. When options bit 1 is 0, `wdt_reset_o` stays low.
- R7: The fired bit stays set until software writes control bit 4 as 0. Writing it as 1 has no effect. While it is set, no new firing occurs: there is no pulse, and a force is ignored.
- R8: Writing control bit 5 as 1 fires at once and clears the count. Bit 5 always reads 0.
- R9: When options bit 2 is 1, a high `ext_force_i` fires the watchdog. When options bit 2 is 0, `ext_force_i` is ignored.
- R10: If the count is nonzero, a keyboard interrupt with control bit 6 set, or a mouse interrupt with control bit 7 set, reloads the last nonzero value written to the count register. If the count is zero, or the enable bit is clear, the interrupt has no effect.
- R11: Control bits 3:0 (timeout routing) and all 8 option bits are stored and read back as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_addr | input | 2 | Register select: 0 options, 1 count, 2 control |
| cfg_wr | input | 1 | Write strobe |
| cfg_wdata | input | 8 | Write data |
| cfg_rdata | output | 8 | Read data for `cfg_addr` (combinational) |
| tick_1s_i | input | 1 | One-second tick enable |
| kbd_irq_i | input | 1 | Keyboard interrupt activity |
| mouse_irq_i | input | 1 | Mouse interrupt activity |
| ext_force_i | input | 1 | External force-timeout request |
| wdt_reset_o | output | 1 | Reset pulse on firing |
| fired_o | output | 1 | Sticky fired flag |

## Verification
The hardest situation to reach from the ports is the minute unit's prescaler phase: it is hidden, and it only shows once 60 ticks have gone by. The bench first lets 30 ticks pass, then rewrites the count. It then shows that 59 more ticks leave the count unchanged and that the 60th tick lowers it, which proves the phase restarted on the write.

A second hard case is a firing blocked by a fired flag that is still set. The bench lets one timeout expire, then arms again without clearing the flag. It then checks that the second expiry produces no pulse.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int REG_W = 8;

  typedef enum logic [1:0] {
    REG_OPT  = 2'd0,
    REG_CNT  = 2'd1,
    REG_CTL  = 2'd2,
    REG_NONE = 2'd3
  } wdt_reg_e;

  // option bits
  localparam int OPT_MIN_UNIT  = 3;
  localparam int OPT_EXT_FORCE = 2;
  localparam int OPT_RST_EN    = 1;
  // control bits
  localparam int CTL_MOUSE_RLD = 7;
  localparam int CTL_KBD_RLD   = 6;
  localparam int CTL_FORCE     = 5;
  localparam int CTL_FIRED     = 4;

  // bits of the control register held as plain storage
  localparam logic [REG_W-1:0] CTL_STORE_MASK = 8'hCF;

  // one count unit elapses on this clock
  function automatic logic unit_step(input logic tick, input logic min_unit,
                                     input logic pre_wrap);
    return tick && (!min_unit || pre_wrap);
  endfunction

  // control read value: stored bits, live fired flag, force always 0
  function automatic logic [REG_W-1:0] ctl_view(input logic [REG_W-1:0] stored,
                                                input logic fired);
    logic [REG_W-1:0] v;
    v = stored & CTL_STORE_MASK;
    v[CTL_FIRED] = fired;
    return v;
  endfunction
endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
  parameter int DIV = 60
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic restart_i,
  output logic wrap_o
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] pre_q;

  assign wrap_o = tick_i && (pre_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         pre_q <= '0;
    else if (restart_i) pre_q <= '0;
    else if (wrap_o)    pre_q <= '0;
    else if (tick_i)    pre_q <= pre_q + PW'(1);
  end

  assert_pre_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pre_q <= LAST);
  assert_restart_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    restart_i |=> pre_q == '0);
endmodule

// File: rtl/wdt_countdown.sv
module wdt_countdown #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear_i,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         reload_i,
  input  logic [W-1:0] reload_val_i,
  input  logic         step_i,
  output logic [W-1:0] cnt_o,
  output logic         expire_o
);
  logic [W-1:0] cnt_q;
  logic         idle;

  assign idle     = !clear_i && !load_i && !reload_i;
  assign expire_o = idle && step_i && (cnt_q == W'(1));
  assign cnt_o    = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     cnt_q <= '0;
    else if (clear_i)               cnt_q <= '0;
    else if (load_i)                cnt_q <= load_val_i;
    else if (reload_i)              cnt_q <= reload_val_i;
    else if (step_i && cnt_q != '0) cnt_q <= cnt_q - W'(1);
  end

  assert_hold_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == '0 && !load_i && !reload_i) |=> cnt_q == '0);
  assert_step_down_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != '0 && step_i && idle) |=> cnt_q == $past(cnt_q) - W'(1));
endmodule

// File: rtl/wdt_pulse.sv
module wdt_pulse #(
  parameter int LEN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire_i,
  output logic pulse_o
);
  localparam int CW = $clog2(LEN + 1);

  logic [CW-1:0] left_q;

  assign pulse_o = (left_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       left_q <= '0;
    else if (fire_i)  left_q <= CW'(LEN);
    else if (pulse_o) left_q <= left_q - CW'(1);
  end

  assert_pulse_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pulse_o) |-> $past(fire_i));
endmodule

// File: rtl/wdt_top.sv
module wdt_top #(
  parameter int CNT_W        = 8,
  parameter int MIN_DIV      = 60,
  parameter int PULSE_CYCLES = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] cfg_addr,
  input  logic       cfg_wr,
  input  logic [7:0] cfg_wdata,
  output logic [7:0] cfg_rdata,
  input  logic       tick_1s_i,
  input  logic       kbd_irq_i,
  input  logic       mouse_irq_i,
  input  logic       ext_force_i,
  output logic       wdt_reset_o,
  output logic       fired_o
);
  import wdt_pkg::*;

  logic [REG_W-1:0] opt_q, ctl_q;
  logic [CNT_W-1:0] rld_val_q, cnt;
  logic             fired_q;

  // named internal events
  logic wr_opt, wr_cnt, wr_ctl;
  logic force_req, fire_ok, fire_evt, clear_cnt;
  logic irq_hit, reload, pre_wrap, step, expire;

  assign wr_opt = cfg_wr && (cfg_addr == REG_OPT);
  assign wr_cnt = cfg_wr && (cfg_addr == REG_CNT);
  assign wr_ctl = cfg_wr && (cfg_addr == REG_CTL);

  assign force_req = (wr_ctl && cfg_wdata[CTL_FORCE]) ||
                     (ext_force_i && opt_q[OPT_EXT_FORCE]);
  assign fire_ok   = !fired_q;
  assign clear_cnt = fire_ok && force_req;
  assign fire_evt  = fire_ok && (force_req || expire);

  assign irq_hit = (kbd_irq_i && ctl_q[CTL_KBD_RLD]) ||
                   (mouse_irq_i && ctl_q[CTL_MOUSE_RLD]);
  assign reload  = irq_hit && (cnt != '0);
  assign step    = unit_step(tick_1s_i, opt_q[OPT_MIN_UNIT], pre_wrap);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      opt_q     <= '0;
      ctl_q     <= '0;
      rld_val_q <= '0;
      fired_q   <= 1'b0;
    end else begin
      if (wr_opt) opt_q <= cfg_wdata;
      if (wr_ctl) ctl_q <= cfg_wdata & CTL_STORE_MASK;
      if (wr_cnt && cfg_wdata != '0) rld_val_q <= CNT_W'(cfg_wdata);
      if (fire_evt)                              fired_q <= 1'b1;
      else if (wr_ctl && !cfg_wdata[CTL_FIRED])  fired_q <= 1'b0;
    end
  end

  wdt_prescaler #(.DIV(MIN_DIV)) u_pre (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_i   (tick_1s_i),
    .restart_i(wr_cnt || reload),
    .wrap_o   (pre_wrap)
  );

  wdt_countdown #(.W(CNT_W)) u_cnt (
    .clk         (clk),
    .rst_n       (rst_n),
    .clear_i     (clear_cnt),
    .load_i      (wr_cnt),
    .load_val_i  (CNT_W'(cfg_wdata)),
    .reload_i    (reload),
    .reload_val_i(rld_val_q),
    .step_i      (step),
    .cnt_o       (cnt),
    .expire_o    (expire)
  );

  wdt_pulse #(.LEN(PULSE_CYCLES)) u_pulse (
    .clk    (clk),
    .rst_n  (rst_n),
    .fire_i (fire_evt && opt_q[OPT_RST_EN]),
    .pulse_o(wdt_reset_o)
  );

  assign fired_o = fired_q;

  always_comb begin
    unique case (cfg_addr)
      REG_OPT: cfg_rdata = opt_q;
      REG_CNT: cfg_rdata = REG_W'(cnt);
      REG_CTL: cfg_rdata = ctl_view(ctl_q, fired_q);
      default: cfg_rdata = '0;
    endcase
  end

  assert_fire_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fire_evt |=> fired_q);
  assert_fired_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (fired_q && !(wr_ctl && !cfg_wdata[CTL_FIRED])) |=> fired_q);
  assert_force_reads_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_addr == REG_CTL) |-> !cfg_rdata[CTL_FORCE]);
  assert_reload_value_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (reload && !wr_cnt && !clear_cnt) |=> cnt == $past(rld_val_q));
endmodule

// File: tb/test_wdt_top.sv
`timescale 1ns/1ps
module test_wdt_top;
  localparam int PULSE = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] cfg_addr = '0;
  logic       cfg_wr = 1'b0;
  logic [7:0] cfg_wdata = '0;
  logic [7:0] cfg_rdata;
  logic       tick_1s_i = 1'b0, kbd_irq_i = 1'b0, mouse_irq_i = 1'b0, ext_force_i = 1'b0;
  logic       wdt_reset_o, fired_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  wdt_top #(.PULSE_CYCLES(PULSE)) i_wdt_top (.*);

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    cfg_addr = a; cfg_wdata = d; cfg_wr = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output int d);
    cfg_addr = a;
    #1;
    d = int'(cfg_rdata);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick_1s_i = 1'b1;
      @(negedge clk);
      tick_1s_i = 1'b0;
    end
  endtask

  task automatic pulse_len(output int n);
    n = 0;
    for (int i = 0; i < 10; i++) begin
      if (wdt_reset_o) n++;
      @(negedge clk);
    end
  endtask

  task automatic t_reset;
    int d;
    rd(0, d); chk("R1 opt", d, 0);
    rd(1, d); chk("R1 cnt", d, 0);
    rd(2, d); chk("R1 ctl", d, 0);
    rd(3, d); chk("R1 addr3", d, 0);
    chk("R1 reset_o", int'(wdt_reset_o), 0);
    chk("R1 fired_o", int'(fired_o), 0);
  endtask

  task automatic t_seconds;
    int d, n;
    wr(0, 8'h00);
    wr(1, 8'd5);
    rd(1, d); chk("R2 arm", d, 5);
    ticks(1); rd(1, d); chk("R3 dec1", d, 4);
    ticks(3); rd(1, d); chk("R3 dec4", d, 1);
    chk("R5 not yet", int'(fired_o), 0);
    ticks(1); rd(1, d); chk("R5 zero", d, 0);
    chk("R5 fired_o", int'(fired_o), 1);
    rd(2, d); chk("R5 ctl bit4", d, 8'h10);
    pulse_len(n); chk("R6 no pulse when disabled", n, 0);
    ticks(3); rd(1, d); chk("R5 stays zero", d, 0);
  endtask

  task automatic t_sticky;
    int d, n;
    wr(0, 8'h02);
    wr(1, 8'd2);
    ticks(2);
    pulse_len(n); chk("R7 no refire pulse", n, 0);
    chk("R7 still fired", int'(fired_o), 1);
    wr(2, 8'h10); chk("R7 write1 keeps", int'(fired_o), 1);
    wr(2, 8'h00); chk("R7 write0 clears", int'(fired_o), 0);
  endtask

  task automatic t_pulse;
    int n;
    wr(0, 8'h02);
    wr(1, 8'd1);
    chk("R6 low before", int'(wdt_reset_o), 0);
    ticks(1);
    pulse_len(n); chk("R6 pulse length", n, PULSE);
    wr(2, 8'h00);
  endtask

  task automatic t_zero;
    int d;
    wr(1, 8'd3);
    wr(1, 8'd0);
    ticks(5);
    rd(1, d); chk("R2 disarm cnt", d, 0);
    chk("R2 disarm no fire", int'(fired_o), 0);
  endtask

  task automatic t_minute;
    int d;
    wr(0, 8'h08);
    wr(1, 8'd2);
    ticks(60); rd(1, d); chk("R4 one minute", d, 1);
    ticks(59); rd(1, d); chk("R4 59 ticks hold", d, 1);
    chk("R4 not fired", int'(fired_o), 0);
    ticks(1); rd(1, d); chk("R4 two minutes", d, 0);
    chk("R4 fired", int'(fired_o), 1);
    wr(2, 8'h00);
  endtask

  task automatic t_restart;
    int d;
    wr(0, 8'h08);
    wr(1, 8'd3);
    ticks(30);
    wr(1, 8'd3);
    ticks(59); rd(1, d); chk("R4 phase restarted", d, 3);
    ticks(1); rd(1, d); chk("R4 after full minute", d, 2);
    wr(1, 8'd0);
    wr(0, 8'h00);
  endtask

  task automatic irq(input bit kbd);
    if (kbd) kbd_irq_i = 1'b1; else mouse_irq_i = 1'b1;
    @(negedge clk);
    kbd_irq_i = 1'b0; mouse_irq_i = 1'b0;
  endtask

  task automatic t_reload;
    int d;
    wr(2, 8'h40);
    wr(1, 8'd6);
    ticks(3); rd(1, d); chk("R10 counted", d, 3);
    irq(1); rd(1, d); chk("R10 kbd reload", d, 6);
    ticks(1); irq(0); rd(1, d); chk("R10 mouse disabled", d, 5);
    wr(2, 8'hC0);
    ticks(2); irq(0); rd(1, d); chk("R10 mouse reload", d, 6);
    wr(1, 8'd0);
    irq(1); rd(1, d); chk("R10 no reload at zero", d, 0);
    chk("R10 no fire", int'(fired_o), 0);
    wr(2, 8'h00);
  endtask

  task automatic t_force;
    int d, n;
    wr(0, 8'h02);
    wr(1, 8'd9);
    wr(2, 8'h22);
    chk("R8 fired", int'(fired_o), 1);
    pulse_len(n); chk("R8 force pulse", n, PULSE);
    rd(1, d); chk("R8 cnt cleared", d, 0);
    rd(2, d); chk("R8 bit5 reads 0, R11 route", d, 8'h12);
    wr(2, 8'h02);
    rd(2, d); chk("R11 route kept", d, 8'h02);
    wr(2, 8'h00);
  endtask

  task automatic t_ext;
    int d;
    wr(0, 8'h00);
    wr(1, 8'd9);
    ext_force_i = 1'b1;
    repeat (3) @(negedge clk);
    ext_force_i = 1'b0;
    chk("R9 ignored fired", int'(fired_o), 0);
    rd(1, d); chk("R9 ignored cnt", d, 9);
    wr(0, 8'h04);
    ext_force_i = 1'b1;
    @(negedge clk);
    ext_force_i = 1'b0;
    chk("R9 enabled fires", int'(fired_o), 1);
    rd(1, d); chk("R9 cnt cleared", d, 0);
    wr(2, 8'h00);
    wr(0, 8'h00);
  endtask

  task automatic t_readback;
    int d;
    wr(0, 8'hA1);
    rd(0, d); chk("R11 opt readback", d, 8'hA1);
    wr(3, 8'hFF);
    rd(3, d); chk("R1 addr3 zero", d, 0);
    wr(0, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_seconds();
    t_sticky();
    t_pulse();
    t_zero();
    t_minute();
    t_restart();
    t_reload();
    t_force();
    t_ext();
    t_readback();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule